// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

This block connects two parallel data buses, called side A and side B, and can carry data in either direction between them. Each side has its own holding register, clocked by its own clock. That register samples the bus on its side at every rising edge of the clock. The capture always happens, whether or not any output is being driven.

One direction input chooses which bus is driven, and an active-low output enable can isolate both buses. The bus that is driven receives one of two sources. It gets either the live value of the opposite bus, passed through combinationally, or the value held in the opposite side's register. A separate select input makes this choice for each direction.

Each bus appears at the block's edge as three plain signals: an input, an output and an output-enable. A pad ring or tri-state wrapper outside the block can combine them into a real bidirectional pin. Any output that is not driven reads as all zeros.

Top module: `xcvr_reg_bridge`

## Requirements
- R1: On every rising edge of `cpab` with `rst_n` high, register A takes the value of `a_in`, whatever the levels of `oe_n`, `dir_ab`, `sel_ab` and `sel_ba`.
- R2: On every rising edge of `cpba` with `rst_n` high, register B takes the value of `b_in`, whatever the levels of `oe_n`, `dir_ab`, `sel_ab` and `sel_ba`.
- R3: A rising edge of a side's clock while `rst_n` is low clears that side's register to zero and leaves the other register unchanged. `rst_n` has no effect on `a_oe` or `b_oe`.
- R4: While `oe_n` is 1, `a_oe` and `b_oe` are both 0.
- R5: While `oe_n` is 0, `dir_ab`=1 gives `b_oe`=1 and `a_oe`=0, and `dir_ab`=0 gives `a_oe`=1 and `b_oe`=0. `a_oe` and `b_oe` are never 1 together.
- R6: While `b_oe` is 1 and `sel_ab`=0, `b_out` equals `a_in` in the same cycle, with no clock edge needed.
- R7: While `b_oe` is 1 and `sel_ab`=1, `b_out` equals register A. It changes only after a rising edge of `cpab`.
- R8: While `a_oe` is 1 and `sel_ba`=0, `a_out` equals `b_in` in the same cycle, with no clock edge needed.
- R9: While `a_oe` is 1 and `sel_ba`=1, `a_out` equals register B. It changes only after a rising edge of `cpba`.
- R10: `sel_ba` has no effect on any output while `dir_ab`=1, and `sel_ab` has no effect on any output while `dir_ab`=0.
- R11: An output whose enable is 0 reads all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpab | input | 1 | Clock for register A; it samples `a_in` on the rising edge |
| cpba | input | 1 | Clock for register B; it samples `b_in` on the rising edge |
| rst_n | input | 1 | Active-low synchronous clear for both registers, each on its own clock |
| oe_n | input | 1 | Active-low output enable; when high, both buses are isolated |
| dir_ab | input | 1 | 1: drive side B; 0: drive side A |
| sel_ab | input | 1 | Source for side B: 0 is live `a_in`, 1 is register A |
| sel_ba | input | 1 | Source for side A: 0 is live `b_in`, 1 is register B |
| a_in | input | W | Value present on bus A |
| a_out | output | W | Value driven onto bus A |
| a_oe | output | 1 | Output enable for bus A |
| b_in | input | W | Value present on bus B |
| b_out | output | W | Value driven onto bus B |
| b_oe | output | 1 | Output enable for bus B |

## Verification
The bench builds the block with its default width, W=8. The data patterns 8'hA5, 8'h5A, 8'hFF and 8'h00 toggle every bit line in both directions, which exposes a stuck or swapped bit in either register or in either multiplexer. The bench gates the two clocks separately. This lets it load one register while the other holds, and lets it show that a stored output changes only on its own side's edge. The bench also checks, every cycle, that the two output enables are never 1 together.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Which bus, if any, the transceiver drives this cycle
    typedef enum logic [1:0] {
        ROUTE_NONE = 2'd0,
        ROUTE_A2B  = 2'd1,
        ROUTE_B2A  = 2'd2
    } route_e;

    // Index of the two sides inside the block
    localparam int SIDE_A = 0;
    localparam int SIDE_B = 1;
    localparam int NUM_SIDES = 2;

endpackage

// File: rtl/xcvr_side_reg.sv
module xcvr_side_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cap_in,
    output logic [W-1:0] held
);
    typedef struct packed {
        logic [W-1:0] data;
    } side_state_t;

    side_state_t state_d;
    side_state_t state_q;

    // Capture is unconditional; only the synchronous clear overrides it
    always_comb begin
        state_d = state_q;
        if (!rst_n) begin
            state_d.data = '0;
        end else begin
            state_d.data = cap_in;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign held = state_q.data;
endmodule

// File: rtl/xcvr_dir_ctl.sv
module xcvr_dir_ctl
    import xcvr_pkg::*;
(
    input  logic   oe_n,
    input  logic   dir_ab,
    output route_e route,
    output logic   a_oe,
    output logic   b_oe
);
    always_comb begin
        route = ROUTE_NONE;
        if (!oe_n) begin
            route = dir_ab ? ROUTE_A2B : ROUTE_B2A;
        end
    end

    // Both enables are decoded from a single enum, so they cannot both be 1
    assign b_oe = (route == ROUTE_A2B);
    assign a_oe = (route == ROUTE_B2A);
endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux #(
    parameter int W = 8
) (
    input  logic         drive_en,
    input  logic         use_stored,
    input  logic [W-1:0] live_val,
    input  logic [W-1:0] stored_val,
    output logic [W-1:0] path_out
);
    always_comb begin
        path_out = '0;
        if (drive_en) begin
            path_out = use_stored ? stored_val : live_val;
        end
    end
endmodule

// File: rtl/xcvr_reg_bridge.sv
module xcvr_reg_bridge
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         cpab,
    input  logic         cpba,
    input  logic         rst_n,
    input  logic         oe_n,
    input  logic         dir_ab,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    // Per-side vectors, indexed by source side (SIDE_A / SIDE_B)
    logic [NUM_SIDES-1:0] side_clk;
    logic [NUM_SIDES-1:0] side_sel;
    logic [NUM_SIDES-1:0] dest_en;
    logic [W-1:0]         side_live [NUM_SIDES];
    logic [W-1:0]         side_held [NUM_SIDES];
    logic [W-1:0]         dest_val  [NUM_SIDES];
    route_e               route;

    logic [W-1:0] reg_a_q;
    logic [W-1:0] reg_b_q;

    xcvr_dir_ctl u_dir (
        .oe_n   (oe_n),
        .dir_ab (dir_ab),
        .route  (route),
        .a_oe   (a_oe),
        .b_oe   (b_oe)
    );

    assign side_clk[SIDE_A]  = cpab;
    assign side_clk[SIDE_B]  = cpba;
    assign side_sel[SIDE_A]  = sel_ab;
    assign side_sel[SIDE_B]  = sel_ba;
    assign side_live[SIDE_A] = a_in;
    assign side_live[SIDE_B] = b_in;
    // A side's data goes to the opposite bus, so that bus's enable gates it
    assign dest_en[SIDE_A]   = b_oe;
    assign dest_en[SIDE_B]   = a_oe;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        xcvr_side_reg #(.W(W)) u_reg (
            .clk    (side_clk[s]),
            .rst_n  (rst_n),
            .cap_in (side_live[s]),
            .held   (side_held[s])
        );

        xcvr_path_mux #(.W(W)) u_mux (
            .drive_en   (dest_en[s]),
            .use_stored (side_sel[s]),
            .live_val   (side_live[s]),
            .stored_val (side_held[s]),
            .path_out   (dest_val[s])
        );
    end

    assign reg_a_q = side_held[SIDE_A];
    assign reg_b_q = side_held[SIDE_B];
    assign b_out   = dest_val[SIDE_A];
    assign a_out   = dest_val[SIDE_B];
endmodule

// File: rtl/xcvr_reg_bridge_chk.sv
module xcvr_reg_bridge_chk #(
    parameter int W = 8
) (
    input logic         cpab,
    input logic         cpba,
    input logic         rst_n,
    input logic         oe_n,
    input logic         dir_ab,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic         b_oe,
    input logic [W-1:0] reg_a_q,
    input logic [W-1:0] reg_b_q
);
    p_capture_a_r1: assert property (@(posedge cpab) disable iff (!rst_n)
        1'b1 |=> reg_a_q == $past(a_in));

    p_capture_b_r2: assert property (@(posedge cpba) disable iff (!rst_n)
        1'b1 |=> reg_b_q == $past(b_in));

    p_isolate_r4: assert property (@(posedge cpab) disable iff (!rst_n)
        oe_n |-> (!a_oe && !b_oe));

    p_oe_exclusive_r5: assert property (@(posedge cpab) disable iff (!rst_n)
        !(a_oe && b_oe));

    p_oe_exclusive_b_r5: assert property (@(posedge cpba) disable iff (!rst_n)
        !(a_oe && b_oe));

    p_live_ab_r6: assert property (@(posedge cpab) disable iff (!rst_n)
        (b_oe && !sel_ab) |-> b_out == a_in);

    p_stored_ab_r7: assert property (@(posedge cpab) disable iff (!rst_n)
        (b_oe && sel_ab) |-> b_out == reg_a_q);

    p_live_ba_r8: assert property (@(posedge cpba) disable iff (!rst_n)
        (a_oe && !sel_ba) |-> a_out == b_in);

    p_stored_ba_r9: assert property (@(posedge cpba) disable iff (!rst_n)
        (a_oe && sel_ba) |-> a_out == reg_b_q);

    p_idle_zero_r11: assert property (@(posedge cpba) disable iff (!rst_n)
        (!a_oe |-> a_out == '0) and (!b_oe |-> b_out == '0));
endmodule

bind xcvr_reg_bridge xcvr_reg_bridge_chk #(.W(W)) u_chk (
    .cpab    (cpab),
    .cpba    (cpba),
    .rst_n   (rst_n),
    .oe_n    (oe_n),
    .dir_ab  (dir_ab),
    .sel_ab  (sel_ab),
    .sel_ba  (sel_ba),
    .a_in    (a_in),
    .a_out   (a_out),
    .a_oe    (a_oe),
    .b_in    (b_in),
    .b_out   (b_out),
    .b_oe    (b_oe),
    .reg_a_q (reg_a_q),
    .reg_b_q (reg_b_q)
);

// File: tb/xcvr_reg_bridge_bench.sv
module xcvr_reg_bridge_bench;
    localparam int W = 8;

    logic clk = 1'b0;
    logic run_ab = 1'b0;
    logic run_ba = 1'b0;
    logic cpab, cpba;
    logic rst_n = 1'b0;
    logic oe_n = 1'b1;
    logic dir_ab = 1'b0;
    logic sel_ab = 1'b0;
    logic sel_ba = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic a_oe, b_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    assign cpab = clk & run_ab;
    assign cpba = clk & run_ba;

    xcvr_reg_bridge #(.W(W)) u_xcvr_reg_bridge (
        .cpab(cpab), .cpba(cpba), .rst_n(rst_n), .oe_n(oe_n),
        .dir_ab(dir_ab), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One rising edge on the selected clocks; inputs change only at negedges
    task automatic pulse(input bit do_ab, input bit do_ba);
        @(negedge clk);
        run_ab = do_ab;
        run_ba = do_ba;
        @(negedge clk);
        run_ab = 1'b0;
        run_ba = 1'b0;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic set_ctl(input bit oe, input bit dir, input bit sab, input bit sba);
        oe_n = oe; dir_ab = dir; sel_ab = sab; sel_ba = sba;
        settle();
    endtask

    // Exclusive enables, checked every cycle (R5)
    always @(negedge clk) begin
        if (rst_n !== 1'bx) begin
            checks++;
            if (a_oe && b_oe) begin
                failures++;
                $display("FAIL R5 both enables actual=%b%b expected=not 11", a_oe, b_oe);
            end
        end
    end

    task automatic t_reset();
        a_in = 8'hC3; b_in = 8'h3C;
        rst_n = 1'b0;
        pulse(1'b1, 1'b1);
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R3 b_oe during reset", {7'd0, b_oe}, 8'd1);
        check("R3 reg A cleared", b_out, 8'h00);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        check("R3 a_oe during reset", {7'd0, a_oe}, 8'd1);
        check("R3 reg B cleared", a_out, 8'h00);
        rst_n = 1'b1;
    endtask

    task automatic t_isolation();
        a_in = 8'hFF; b_in = 8'hFF;
        for (int d = 0; d < 2; d++) begin
            set_ctl(1'b1, d[0], 1'b0, 1'b0);
            check("R4 a_oe isolated", {7'd0, a_oe}, 8'd0);
            check("R4 b_oe isolated", {7'd0, b_oe}, 8'd0);
            check("R11 a_out idle", a_out, 8'h00);
            check("R11 b_out idle", b_out, 8'h00);
        end
    endtask

    task automatic t_capture_isolated();
        set_ctl(1'b1, 1'b0, 1'b1, 1'b1);
        a_in = 8'hA5; b_in = 8'h5A;
        pulse(1'b1, 1'b1);
        a_in = 8'h00; b_in = 8'h00;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R1 capture while isolated", b_out, 8'hA5);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        check("R2 capture while isolated", a_out, 8'h5A);
    endtask

    task automatic t_live_ab();
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        check("R5 a_oe off in A-to-B", {7'd0, a_oe}, 8'd0);
        check("R5 b_oe on in A-to-B", {7'd0, b_oe}, 8'd1);
        for (int i = 0; i < 4; i++) begin
            a_in = 8'h11 << i ^ 8'hF0;
            settle();
            check("R6 live A to B", b_out, 8'h11 << i ^ 8'hF0);
            check("R11 a_out undriven", a_out, 8'h00);
        end
    endtask

    task automatic t_live_ba();
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
        check("R5 a_oe on in B-to-A", {7'd0, a_oe}, 8'd1);
        check("R5 b_oe off in B-to-A", {7'd0, b_oe}, 8'd0);
        for (int i = 0; i < 4; i++) begin
            b_in = 8'h81 >> i ^ 8'h0F;
            settle();
            check("R8 live B to A", a_out, 8'h81 >> i ^ 8'h0F);
            check("R11 b_out undriven", b_out, 8'h00);
        end
    endtask

    task automatic t_stored_ab();
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        a_in = 8'h11;
        pulse(1'b1, 1'b0);
        settle();
        check("R7 stored A after edge", b_out, 8'h11);
        a_in = 8'h22;
        settle();
        check("R7 stored A holds without edge", b_out, 8'h11);
        pulse(1'b0, 1'b1);
        settle();
        check("R7 stored A holds on other clock", b_out, 8'h11);
        pulse(1'b1, 1'b0);
        settle();
        check("R7 stored A updates", b_out, 8'h22);
    endtask

    task automatic t_stored_ba();
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        b_in = 8'h44;
        pulse(1'b0, 1'b1);
        settle();
        check("R9 stored B after edge", a_out, 8'h44);
        b_in = 8'hFF;
        settle();
        check("R9 stored B holds without edge", a_out, 8'h44);
        pulse(1'b1, 1'b0);
        settle();
        check("R9 stored B holds on other clock", a_out, 8'h44);
        pulse(1'b0, 1'b1);
        settle();
        check("R9 stored B updates", a_out, 8'hFF);
    endtask

    task automatic t_ignored_select();
        // reg A = 22, reg B = FF from earlier; live buses differ from both
        a_in = 8'h6B; b_in = 8'h94;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R10 A-to-B before sel_ba toggle", b_out, 8'h22);
        set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
        check("R10 sel_ba ignored b_out", b_out, 8'h22);
        check("R10 sel_ba ignored a_out", a_out, 8'h00);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
        check("R10 B-to-A before sel_ab toggle", a_out, 8'h94);
        set_ctl(1'b0, 1'b0, 1'b1, 1'b0);
        check("R10 sel_ab ignored a_out", a_out, 8'h94);
        check("R10 sel_ab ignored b_out", b_out, 8'h00);
    endtask

    task automatic t_reset_one_side();
        rst_n = 1'b0;
        pulse(1'b1, 1'b0);
        rst_n = 1'b1;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R3 reg A cleared on own edge", b_out, 8'h00);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        check("R3 reg B untouched", a_out, 8'hFF);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_isolation();
        t_capture_isolated();
        t_live_ab();
        t_live_ba();
        t_stored_ab();
        t_stored_ba();
        t_ignored_select();
        t_reset_one_side();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule